// File: doc/BRIEF.md
# Receive Timestamp Buffer Margin Inserter

This block sits on an Ethernet receive path between the frame source and the buffer memory. When the first beat of a frame is accepted it samples a free-running 64-bit time value. It then writes the frame into a buffer through a plain word write port. An optional reserved margin of 64 bytes comes first, and the captured time sits in an 8-byte slot at byte 48 of that margin. The payload follows the margin.

Two configuration bits are sampled with the first beat of each frame. One enables timestamping; when it is off the slot is written as zeros. The other enables writing the margin; when it is off the payload starts at byte 0. A done pulse carries the payload length. A frame that ends with an abort marker raises an error pulse and never produces a done pulse. Nothing is written beyond the last payload byte, so whatever space the buffer keeps after the payload is left untouched.

The input is a 64-bit word stream with valid/ready handshaking, start and end markers, an abort marker and a count of valid bytes on the final beat. Byte lane i of a word (bits 8i+7..8i) maps to byte address 8*word_address + i.

Top module: `rx_ts_margin_inserter`

## Requirements
- R1: The time value is taken on the clock edge that accepts the start beat (in_valid, in_ready and in_sof high). It is written in big-endian order at bytes 48..55 of the margin, with the most significant byte at byte 48. Stalls after acceptance do not change it.
- R2: With cfg_ts_en low at frame start, bytes 48..55 of the margin are written as zero.
- R3: With cfg_margin_en high at frame start, the margin covers bytes 0..63 and every margin byte outside the time slot is written as zero.
- R4: With cfg_margin_en low at frame start, no margin is written and payload byte 0 lands at byte address 0.
- R5: Payload byte n lands at byte address base+n, where base is 64 with the margin and 0 without it. On the final word only the low in_nbytes lanes are strobed (in_nbytes is 1..8), so no byte past the payload end is written.
- R6: done pulses for one cycle, exactly one cycle after the last payload write, with done_len equal to the payload length in bytes.
- R7: A beat accepted with in_abort high is not written. err pulses on the next cycle and no done pulse is issued for that frame.
- R8: While the margin and the start beat are being written, in_ready is low. The second beat of a frame waits 9 cycles with the margin and 1 cycle without it.
- R9: While rst is high, wr_en, done and err are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ts_en | input | 1 | Timestamp enable, sampled at frame start |
| cfg_margin_en | input | 1 | Start margin enable, sampled at frame start |
| time_now | input | 64 | Free-running time value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_sof | input | 1 | First beat of frame |
| in_eof | input | 1 | Last beat of frame |
| in_abort | input | 1 | Frame aborted, beat discarded |
| in_data | input | 64 | Beat data, lane 0 first |
| in_nbytes | input | 4 | Valid bytes on the final beat (1..8) |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer word address |
| wr_data | output | 64 | Buffer write data |
| wr_strb | output | 8 | Byte lane enables |
| done | output | 1 | Frame stored |
| done_len | output | LEN_W | Payload length in bytes |
| err | output | 1 | Frame aborted |

## Verification
The bench aims at the time slot. A design that samples time on a later cycle, or while it stalls for the margin, gives a slot value off by some cycles. A design that swaps byte order gives a reversed slot, and one that keeps the last value while timestamping is off leaves stale bytes. Payload lengths of 1, 8, 9 and 64 bytes, with and without the margin, catch an off-by-one base address, a full strobe on a partial last word (the bench prefills the buffer and checks the bytes just past the end), and a done pulse that comes a cycle early or late or carries the wrong length. An aborted frame must show an error pulse and no done pulse.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

    localparam int WORD_BYTES = 8;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int NB_W       = $clog2(WORD_BYTES + 1);

    typedef logic [WORD_W-1:0]     word_t;
    typedef logic [WORD_BYTES-1:0] strb_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARGIN,
        ST_HOLD,
        ST_STREAM
    } wr_state_e;

    typedef struct packed {
        word_t           data;
        logic            eof;
        logic [NB_W-1:0] nbytes;
    } beat_t;

    // Most significant byte of the time value goes to the lowest byte lane.
    function automatic word_t to_big_endian(input logic [63:0] t);
        word_t w;
        for (int i = 0; i < 8; i++) begin
            w[8*i +: 8] = t[63-8*i -: 8];
        end
        return w;
    endfunction

    function automatic strb_t lane_mask(input logic [NB_W-1:0] n);
        strb_t m;
        for (int i = 0; i < WORD_BYTES; i++) begin
            m[i] = (NB_W'(i) < n);
        end
        return m;
    endfunction

    function automatic logic [NB_W-1:0] beat_bytes(input beat_t b);
        return b.eof ? b.nbytes : NB_W'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/rxts_capture.sv
module rxts_capture
    import rxts_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        ts_en,
    input  logic [63:0] time_now,
    output word_t       ts_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_word <= '0;
        end else if (take) begin
            ts_word <= ts_en ? to_big_endian(time_now) : '0;
        end
    end

    // R1: captured value is frozen between frame starts
    p_ts_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(ts_word));

endmodule

// File: rtl/rxts_margin_gen.sv
module rxts_margin_gen
    import rxts_pkg::*;
#(
    parameter int MW      = 8,
    parameter int TS_WORD = 6,
    parameter int IDX_W   = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  word_t            ts_word,
    output word_t            word
);

    generate
        if (TS_WORD < MW) begin : g_slot
            assign word = (idx == IDX_W'(TS_WORD)) ? ts_word : '0;
        end else begin : g_noslot
            assign word = '0;
        end
    endgenerate

endmodule

// File: rtl/rxts_writer.sv
module rxts_writer
    import rxts_pkg::*;
#(
    parameter int MW     = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_margin_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic              in_abort,
    input  beat_t             in_beat,
    output logic              take,
    output logic [IDX_W-1:0]  idx,
    input  word_t             margin_word,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output word_t             wr_data,
    output strb_t             wr_strb,
    output logic              done,
    output logic [LEN_W-1:0]  done_len,
    output logic              err
);

    localparam strb_t FULL = '1;

    wr_state_e         state;
    beat_t             hold;
    logic              margin_on;
    logic [ADDR_W-1:0] waddr;
    logic [LEN_W-1:0]  len;
    logic              wr_last;
    logic              acc;
    logic [ADDR_W-1:0] base;

    assign in_ready = (state == ST_IDLE) || (state == ST_STREAM);
    assign acc      = in_valid && in_ready;
    assign take     = acc && (state == ST_IDLE) && in_sof && !in_abort;
    assign base     = margin_on ? ADDR_W'(MW) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hold      <= '0;
            margin_on <= 1'b0;
            idx       <= '0;
            waddr     <= '0;
            len       <= '0;
            wr_en     <= 1'b0;
            wr_last   <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_strb   <= '0;
            done      <= 1'b0;
            done_len  <= '0;
            err       <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            wr_last <= 1'b0;
            err     <= 1'b0;
            done    <= wr_en && wr_last;
            if (wr_en && wr_last) begin
                done_len <= len;
            end
            case (state)
                ST_IDLE: begin
                    if (acc && in_sof) begin
                        if (in_abort) begin
                            err <= 1'b1;
                        end else begin
                            hold      <= in_beat;
                            margin_on <= cfg_margin_en;
                            idx       <= '0;
                            state     <= cfg_margin_en ? ST_MARGIN : ST_HOLD;
                        end
                    end
                end
                ST_MARGIN: begin
                    wr_en   <= 1'b1;
                    wr_addr <= ADDR_W'(idx);
                    wr_data <= margin_word;
                    wr_strb <= FULL;
                    idx     <= idx + 1'b1;
                    if (idx == IDX_W'(MW - 1)) begin
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    wr_en   <= 1'b1;
                    wr_addr <= base;
                    wr_data <= hold.data;
                    wr_strb <= lane_mask(beat_bytes(hold));
                    len     <= LEN_W'(beat_bytes(hold));
                    waddr   <= base + 1'b1;
                    wr_last <= hold.eof;
                    state   <= hold.eof ? ST_IDLE : ST_STREAM;
                end
                default: begin
                    if (acc) begin
                        if (in_abort) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            wr_en   <= 1'b1;
                            wr_addr <= waddr;
                            wr_data <= in_beat.data;
                            wr_strb <= lane_mask(beat_bytes(in_beat));
                            len     <= len + LEN_W'(beat_bytes(in_beat));
                            waddr   <= waddr + 1'b1;
                            wr_last <= in_beat.eof;
                            if (in_beat.eof) begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                end
            endcase
        end
    end

    // R6: done only ever follows the final write of a frame by one cycle
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_en && wr_last));

    // R7: an abort is never followed by a done pulse
    p_abort_no_done_r7: assert property (@(posedge clk) disable iff (rst)
        err |=> !done);

    // R5: strobes are a non-empty run of low lanes
    p_strb_contig_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_strb != '0) && (((wr_strb + 1) & wr_strb) == 0));

    // R5: back-to-back writes of one frame step the address by one word
    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && !$past(wr_last))
            |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    // R8: no input accepted while margin words are written
    p_margin_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MARGIN) |=> !$past(acc));

endmodule

// File: rtl/rx_ts_margin_inserter.sv
module rx_ts_margin_inserter
    import rxts_pkg::*;
#(
    parameter int MARGIN_BYTES = 64,
    parameter int TS_OFFSET    = 48,
    parameter int ADDR_W       = 12,
    parameter int LEN_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ts_en,
    input  logic              cfg_margin_en,
    input  logic [63:0]       time_now,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_abort,
    input  logic [63:0]       in_data,
    input  logic [3:0]        in_nbytes,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    output logic [7:0]        wr_strb,
    output logic              done,
    output logic [LEN_W-1:0]  done_len,
    output logic              err
);

    localparam int MW      = MARGIN_BYTES / WORD_BYTES;
    localparam int TS_WORD = TS_OFFSET / WORD_BYTES;
    localparam int IDX_W   = (MW > 1) ? $clog2(MW) : 1;

    beat_t            beat;
    logic             take;
    logic [IDX_W-1:0] idx;
    word_t            ts_word;
    word_t            margin_word;

    assign beat.data   = in_data;
    assign beat.eof    = in_eof;
    assign beat.nbytes = in_nbytes;

    rxts_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .ts_en    (cfg_ts_en),
        .time_now (time_now),
        .ts_word  (ts_word)
    );

    rxts_margin_gen #(
        .MW      (MW),
        .TS_WORD (TS_WORD),
        .IDX_W   (IDX_W)
    ) u_margin (
        .idx     (idx),
        .ts_word (ts_word),
        .word    (margin_word)
    );

    rxts_writer #(
        .MW     (MW),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_writer (
        .clk           (clk),
        .rst           (rst),
        .cfg_margin_en (cfg_margin_en),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_sof        (in_sof),
        .in_abort      (in_abort),
        .in_beat       (beat),
        .take          (take),
        .idx           (idx),
        .margin_word   (margin_word),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wr_strb       (wr_strb),
        .done          (done),
        .done_len      (done_len),
        .err           (err)
    );

endmodule

// File: tb/test_rx_ts_margin_inserter.sv
`timescale 1ns/1ps
module test_rx_ts_margin_inserter;

    localparam int ADDR_W = 12;
    localparam int LEN_W  = 16;
    localparam int MEMB   = 256;

    logic clk = 1'b0;
    logic rst;
    logic cfg_ts_en, cfg_margin_en;
    logic [63:0] time_now = 64'h0123_4567_89AB_0000;
    logic in_valid, in_ready, in_sof, in_eof, in_abort;
    logic [63:0] in_data;
    logic [3:0]  in_nbytes;
    logic wr_en, done, err;
    logic [ADDR_W-1:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_strb;
    logic [LEN_W-1:0] done_len;

    always #2.5 clk = ~clk;
    always @(posedge clk) time_now <= time_now + 64'd1;

    rx_ts_margin_inserter i_rx_ts_margin_inserter (
        .clk(clk), .rst(rst), .cfg_ts_en(cfg_ts_en), .cfg_margin_en(cfg_margin_en),
        .time_now(time_now), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort),
        .in_data(in_data), .in_nbytes(in_nbytes), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .done(done), .done_len(done_len), .err(err)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0;
    logic [7:0] mem [MEMB];
    logic [7:0] pay [64];
    int done_seen, err_seen, last_wr_cyc, done_cyc;
    logic [LEN_W-1:0] got_len;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%h expected=%h", cyc, 0);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                last_wr_cyc = cyc;
                for (int i = 0; i < 8; i++) begin
                    if (wr_strb[i] && (int'(wr_addr) * 8 + i) < MEMB)
                        mem[int'(wr_addr) * 8 + i] = wr_data[8*i +: 8];
                end
            end
            if (done) begin
                done_seen++;
                done_cyc = cyc;
                got_len  = done_len;
            end
            if (err) err_seen++;
        end
    end

    task automatic run_frame(input int len, input bit m, input bit t, input bit abrt, input bit gaps);
        int nb, nbeats, stalls, base, bad;
        bit acc;
        logic [63:0] ts_exp, slot, d;
        for (int i = 0; i < MEMB; i++) mem[i] = 8'hA5;
        done_seen = 0; err_seen = 0; ts_exp = '0;
        cfg_margin_en = m; cfg_ts_en = t;
        for (int i = 0; i < 64; i++) pay[i] = 8'($urandom);
        nb = (len + 7) / 8;
        nbeats = abrt ? 2 : nb;
        for (int b = 0; b < nbeats; b++) begin
            if (b > 1 && gaps && ($urandom % 3 == 0)) begin
                in_valid = 0;
                @(negedge clk);
            end
            for (int i = 0; i < 8; i++)
                d[8*i +: 8] = (b*8 + i < len) ? pay[b*8 + i] : 8'($urandom);
            in_valid  = 1;
            in_sof    = (b == 0);
            in_eof    = !abrt && (b == nbeats - 1);
            in_abort  = abrt && (b == nbeats - 1);
            in_data   = d;
            in_nbytes = 4'(len - 8*(nb - 1));
            stalls = 0;
            forever begin
                #1;
                acc = in_ready;
                if (b == 0) ts_exp = time_now;
                @(posedge clk);
                @(negedge clk);
                if (acc) break;
                stalls++;
            end
            if (b == 1)
                chk(stalls == (m ? 9 : 1), "R8 stall after start", 64'(stalls), m ? 64'd9 : 64'd1);
        end
        in_valid = 0; in_sof = 0; in_eof = 0; in_abort = 0;
        repeat (20) @(negedge clk);
        if (abrt) begin
            chk(err_seen == 1, "R7 err pulse", 64'(err_seen), 64'd1);
            chk(done_seen == 0, "R7 no done", 64'(done_seen), 64'd0);
            return;
        end
        chk(done_seen == 1, "R6 done count", 64'(done_seen), 64'd1);
        chk(got_len == LEN_W'(len), "R6 done_len", 64'(got_len), 64'(len));
        chk(done_cyc - last_wr_cyc == 1, "R6 done timing", 64'(done_cyc - last_wr_cyc), 64'd1);
        base = m ? 64 : 0;
        if (m) begin
            slot = '0;
            for (int k = 0; k < 8; k++) slot = {slot[55:0], mem[48 + k]};
            if (t) chk(slot == ts_exp, "R1 slot value", slot, ts_exp);
            else   chk(slot == 64'd0, "R2 slot zero", slot, 64'd0);
            bad = 0;
            for (int i = 0; i < 64; i++)
                if ((i < 48 || i > 55) && mem[i] != 8'h00) bad++;
            chk(bad == 0, "R3 margin zero", 64'(bad), 64'd0);
        end
        bad = 0;
        for (int i = 0; i < len; i++) if (mem[base + i] != pay[i]) bad++;
        chk(bad == 0, m ? "R5 payload placement" : "R4 payload at zero", 64'(bad), 64'd0);
        bad = 0;
        for (int i = 0; i < 8; i++) if (mem[base + len + i] != 8'hA5) bad++;
        chk(bad == 0, "R5 nothing past end", 64'(bad), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1; in_valid = 0; in_sof = 0; in_eof = 0; in_abort = 0;
        in_data = '0; in_nbytes = '0; cfg_ts_en = 0; cfg_margin_en = 0;
        last_wr_cyc = 0; done_cyc = 0; got_len = '0;
        repeat (4) @(negedge clk);
        chk(!wr_en && !done && !err, "R9 reset outputs", {61'd0, wr_en, done, err}, 64'd0);
        chk(in_ready == 1'b1, "R9 reset ready", 64'(in_ready), 64'd1);
        rst = 0;
        @(negedge clk);
        run_frame(1,  1, 1, 0, 0);
        run_frame(8,  0, 1, 0, 0);
        run_frame(9,  1, 1, 0, 0);
        run_frame(64, 1, 0, 0, 1);
        run_frame(17, 0, 0, 0, 1);
        run_frame(20, 1, 1, 1, 0);
        run_frame(12, 1, 1, 0, 0);
        for (int f = 0; f < 16; f++)
            run_frame(1 + int'($urandom % 64), 1'($urandom), 1'($urandom), 1'($urandom % 5 == 0), 1);
        finish_run();
    end

endmodule